// File: doc/BRIEF.md
# Legacy IO Window Bridge with Byte-Order Correction

The bridge claims a 64 KiB slice of the processor's physical address space, based at 0x7000_0000, and turns each access that lands in it into a single cycle on a legacy IO port bus. That bus uses 16-bit port numbers, and the port number is the low half of the processor address. Byte, halfword and word accesses each produce an IO cycle of the same size.

Peripherals on the IO bus use little-endian byte order. When the processor side is big-endian, the bridge reverses the byte order of halfword and word data in both directions. Write data is reversed before it goes onto the IO bus, and read data is reversed before it goes back to the processor. Byte accesses pass through unchanged. A parameter sets the processor byte order, and in little-endian mode no size is swapped.

The bridge does not claim requests outside the window or with the reserved size code, so those requests never receive a ready. Read data is zero-extended to 32 bits.

Top module: `io_window_bridge`

## Requirements
- R1: A request is claimed only when req_addr[31:16] equals 0x7000, so the window covers 0x7000_0000 through 0x7000_FFFF. For a request outside the window, req_ready stays 0 and io_strobe stays 0 for as long as the request is held.
- R2: During the IO cycle, io_addr equals req_addr[15:0] of the claimed request.
- R3: req_size is encoded as 00 = byte, 01 = halfword and 10 = word. During the IO cycle, io_size equals req_size and io_write equals req_write (1 = write).
- R4: io_strobe is high for exactly one cycle, starting in the cycle after the clock edge that sees a claimable request. req_ready is high for exactly one cycle, in the cycle after the strobe. io_rdata is sampled during the strobe cycle.
- R5: In big-endian mode, a halfword write drives io_wdata = {16'h0, req_wdata[7:0], req_wdata[15:8]}.
- R6: In big-endian mode, a word write drives io_wdata with bytes 0..3 of req_wdata in reversed order.
- R7: In big-endian mode, a halfword read returns {16'h0, io_rdata[7:0], io_rdata[15:8]}, and a word read returns io_rdata with its four bytes reversed.
- R8: Byte accesses are never swapped. A byte write drives io_wdata = {24'h0, req_wdata[7:0]}, and a byte read returns {24'h0, io_rdata[7:0]}.
- R9: In little-endian mode, data passes straight through. A halfword access masks or zero-extends to the low 16 bits, and a word access passes all 32 bits unchanged.
- R10: The bridge never claims a request with size code 11. For such a request, req_ready and io_strobe stay 0.
- R11: After reset, req_ready = 0, io_strobe = 0, io_write = 0, io_addr = 0 and io_size = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present; held until req_ready |
| req_ready | output | 1 | One-cycle completion of a claimed request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | 32 | Processor physical address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_rdata | output | 32 | Read data, zero-extended; valid with req_ready |
| io_strobe | output | 1 | One-cycle IO cycle marker |
| io_write | output | 1 | IO cycle direction |
| io_size | output | 2 | IO cycle size, same encoding as req_size |
| io_addr | output | 16 | IO port number |
| io_wdata | output | 32 | IO write data, little-endian |
| io_rdata | input | 32 | IO read data, sampled during io_strobe |

## Verification
The IO command register holds the port number, size, direction and data. An error in that register shows on the IO pins during the strobe cycle, which is one cycle after the request is accepted. An error in the read-capture register or the return swap shows on req_rdata in the ready cycle, which is one cycle later. A sequencer that leaves its idle state wrongly shows up in one of three ways: a strobe for an unclaimed address, a strobe that lasts two cycles, or a ready that is missing or out of place. Each of these is visible within three cycles of the request, so every access is checked field by field at those two fixed cycles, in both byte orders, and at both window edges.

// File: rtl/iobr_pkg.sv
package iobr_pkg;

    localparam int IOBR_DATA_W = 32;
    localparam int IOBR_PORT_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_RESP  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [IOBR_PORT_W-1:0] port;
        xfer_size_e             size;
        logic                   write;
        logic [IOBR_DATA_W-1:0] data;
    } io_cmd_t;

    // Keep only the byte lanes that belong to the access size.
    function automatic logic [IOBR_DATA_W-1:0] lane_mask(
        input logic [IOBR_DATA_W-1:0] d,
        input xfer_size_e             sz
    );
        logic [IOBR_DATA_W-1:0] r;
        r = '0;
        case (sz)
            SZ_BYTE: r[7:0]  = d[7:0];
            SZ_HALF: r[15:0] = d[15:0];
            default: r       = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iobr_window_decode.sv
module iobr_window_decode
    import iobr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                PORT_W   = IOBR_PORT_W,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h7000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  xfer_size_e        size,
    output logic              claim,
    output logic [PORT_W-1:0] port
);
    localparam int                   HI_W    = ADDR_W - PORT_W;
    localparam logic [HI_W-1:0]      BASE_HI = WIN_BASE[ADDR_W-1:PORT_W];

    logic hit;

    always_comb begin
        hit   = (addr[ADDR_W-1:PORT_W] == BASE_HI);
        claim = hit && (size != SZ_RSVD);
        port  = addr[PORT_W-1:0];
    end
endmodule

// File: rtl/iobr_lane_swap.sv
module iobr_lane_swap
    import iobr_pkg::*;
#(
    parameter int DATA_W     = IOBR_DATA_W,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  xfer_size_e        size,
    output logic [DATA_W-1:0] dout
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] masked;

    always_comb masked = lane_mask(din, size);

    generate
        if (BIG_ENDIAN) begin : g_be
            always_comb begin
                dout = '0;
                case (size)
                    SZ_HALF: begin
                        for (int i = 0; i < 2; i++)
                            dout[8*i +: 8] = masked[8*(1-i) +: 8];
                    end
                    SZ_WORD: begin
                        for (int i = 0; i < BYTES; i++)
                            dout[8*i +: 8] = masked[8*(BYTES-1-i) +: 8];
                    end
                    default: dout = masked;
                endcase
            end
        end else begin : g_le
            always_comb dout = masked;
        end
    endgenerate
endmodule

// File: rtl/iobr_access_seq.sv
module iobr_access_seq
    import iobr_pkg::*;
#(
    parameter int DATA_W = IOBR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              claim,
    input  io_cmd_t           cmd_in,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              req_ready,
    output logic              io_strobe,
    output io_cmd_t           cmd_q,
    output logic [DATA_W-1:0] rd_q
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            rd_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && claim) begin
                        cmd_q   <= cmd_in;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    rd_q    <= io_rdata;
                    state_q <= ST_RESP;
                end
                ST_RESP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        io_strobe = (state_q == ST_ISSUE);
        req_ready = (state_q == ST_RESP);
    end
endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
    import iobr_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = IOBR_DATA_W,
    parameter int                PORT_W     = IOBR_PORT_W,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h7000_0000,
    parameter bit                BIG_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              io_strobe,
    output logic              io_write,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata
);
    xfer_size_e        size_in;
    logic              claim;
    logic [PORT_W-1:0] port;
    logic [DATA_W-1:0] wdata_swapped;
    io_cmd_t           cmd_in;
    io_cmd_t           cmd_q;
    logic [DATA_W-1:0] rd_q;

    always_comb size_in = xfer_size_e'(req_size);

    iobr_window_decode #(
        .ADDR_W   (ADDR_W),
        .PORT_W   (PORT_W),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .addr  (req_addr),
        .size  (size_in),
        .claim (claim),
        .port  (port)
    );

    iobr_lane_swap #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_wr_swap (
        .din  (req_wdata),
        .size (size_in),
        .dout (wdata_swapped)
    );

    always_comb begin
        cmd_in.port  = port;
        cmd_in.size  = size_in;
        cmd_in.write = req_write;
        cmd_in.data  = req_write ? wdata_swapped : '0;
    end

    iobr_access_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .claim     (claim),
        .cmd_in    (cmd_in),
        .io_rdata  (io_rdata),
        .req_ready (req_ready),
        .io_strobe (io_strobe),
        .cmd_q     (cmd_q),
        .rd_q      (rd_q)
    );

    iobr_lane_swap #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_rd_swap (
        .din  (rd_q),
        .size (cmd_q.size),
        .dout (req_rdata)
    );

    always_comb begin
        io_addr  = cmd_q.port;
        io_size  = cmd_q.size;
        io_write = cmd_q.write;
        io_wdata = cmd_q.data;
    end
endmodule

// File: rtl/iobr_checker.sv
module iobr_checker #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                PORT_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h7000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_rdata,
    input logic              io_strobe,
    input logic              io_write,
    input logic [1:0]        io_size,
    input logic [PORT_W-1:0] io_addr
);
    a_r1_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> ($past(req_addr[ADDR_W-1:PORT_W]) == WIN_BASE[ADDR_W-1:PORT_W]));

    a_r2_port_is_low_addr: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> (io_addr == $past(req_addr[PORT_W-1:0])));

    a_r3_size_and_dir: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> (io_size == $past(req_size) && io_write == $past(req_write)));

    a_r4_single_strobe_then_ready: assert property (@(posedge clk) disable iff (rst)
        io_strobe |=> (!io_strobe && req_ready));

    a_r4_ready_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> $past(io_strobe));

    a_r8_byte_read_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !io_write && io_size == 2'b00) |-> (req_rdata[DATA_W-1:8] == '0));

    a_r10_no_reserved_size: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> (io_size != 2'b11));
endmodule

bind io_window_bridge iobr_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PORT_W   (PORT_W),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_rdata (req_rdata),
    .io_strobe (io_strobe),
    .io_write  (io_write),
    .io_size   (io_size),
    .io_addr   (io_addr)
);

// File: tb/sim_io_window_bridge.sv
`timescale 1ns/1ps
module sim_io_window_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_be = 1'b0;
    logic        vld_le = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  sz = 2'b00;
    logic [31:0] addr = 32'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] pdata = 32'h0;

    logic        rdy_be, rdy_le, stb_be, stb_le, iow_be, iow_le;
    logic [1:0]  iosz_be, iosz_le;
    logic [15:0] ioa_be, ioa_le;
    logic [31:0] iowd_be, iowd_le, rd_be, rd_le;

    always #5 clk = ~clk;

    io_window_bridge u0 (
        .clk(clk), .rst(rst), .req_valid(vld_be), .req_ready(rdy_be),
        .req_write(wr), .req_size(sz), .req_addr(addr), .req_wdata(wdata),
        .req_rdata(rd_be), .io_strobe(stb_be), .io_write(iow_be),
        .io_size(iosz_be), .io_addr(ioa_be), .io_wdata(iowd_be), .io_rdata(pdata)
    );

    io_window_bridge #(.BIG_ENDIAN(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_valid(vld_le), .req_ready(rdy_le),
        .req_write(wr), .req_size(sz), .req_addr(addr), .req_wdata(wdata),
        .req_rdata(rd_le), .io_strobe(stb_le), .io_write(iow_le),
        .io_size(iosz_le), .io_addr(ioa_le), .io_wdata(iowd_le), .io_rdata(pdata)
    );

    typedef struct {
        logic [15:0] port;
        logic [1:0]  size;
        logic        write;
        logic [31:0] wdata;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails = 0;
    int   strobe_cnt = 0;
    int   ready_cnt = 0;
    logic sel_le = 1'b0;
    logic strobe_prev = 1'b0;
    bit   done = 1'b0;

    // Independent expectation: the lanes of the size, reversed when big-endian.
    function automatic logic [31:0] model(input logic [31:0] d, input logic [1:0] s,
                                          input logic be);
        logic [31:0] r;
        if (s == 2'b00)      r = {24'h0, d[7:0]};
        else if (s == 2'b01) r = be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
        else                 r = be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Monitor: compares IO cycles and returned data against the scoreboard.
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic        m_stb, m_rdy, m_w;
            logic [1:0]  m_sz;
            logic [15:0] m_a;
            logic [31:0] m_wd, m_rd;
            m_stb = sel_le ? stb_le : stb_be;
            m_rdy = sel_le ? rdy_le : rdy_be;
            m_w   = sel_le ? iow_le : iow_be;
            m_sz  = sel_le ? iosz_le : iosz_be;
            m_a   = sel_le ? ioa_le : ioa_be;
            m_wd  = sel_le ? iowd_le : iowd_be;
            m_rd  = sel_le ? rd_le : rd_be;
            if (m_stb) begin
                strobe_cnt++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R1 unexpected strobe", {16'h0, m_a}, 32'h0);
                end else begin
                    check(m_a == sb_q[0].port, {"R2 port ", sb_q[0].tag}, {16'h0, m_a},
                          {16'h0, sb_q[0].port});
                    check(m_sz == sb_q[0].size && m_w == sb_q[0].write,
                          {"R3 size/dir ", sb_q[0].tag}, {29'h0, m_w, m_sz},
                          {29'h0, sb_q[0].write, sb_q[0].size});
                    if (sb_q[0].write)
                        check(m_wd == sb_q[0].wdata, {"wdata ", sb_q[0].tag}, m_wd,
                              sb_q[0].wdata);
                end
                if (strobe_prev)
                    check(1'b0, "R4 strobe longer than one cycle", 32'h1, 32'h0);
            end
            if (m_rdy) begin
                ready_cnt++;
                check(strobe_prev, "R4 ready not right after strobe", {31'h0, strobe_prev},
                      32'h1);
                if (sb_q.size() != 0) begin
                    if (!sb_q[0].write)
                        check(m_rd == sb_q[0].rdata, {"rdata ", sb_q[0].tag}, m_rd,
                              sb_q[0].rdata);
                    void'(sb_q.pop_front());
                end
            end
            strobe_prev = m_stb;
        end
    end

    // Driver: pushes the expected item, presents the request, waits for ready.
    task automatic access(input logic le, input logic [31:0] a, input logic [1:0] s,
                          input logic w, input logic [31:0] wd, input logic [31:0] pd,
                          input string tag);
        exp_t e;
        e.port  = a[15:0];
        e.size  = s;
        e.write = w;
        e.wdata = model(wd, s, !le);
        e.rdata = model(pd, s, !le);
        e.tag   = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        sel_le = le;
        addr = a; sz = s; wr = w; wdata = wd; pdata = pd;
        if (le) vld_le = 1'b1; else vld_be = 1'b1;
        do @(negedge clk); while (!(le ? rdy_le : rdy_be));
        @(posedge clk); #1;
        vld_le = 1'b0; vld_be = 1'b0;
    endtask

    // Holds an unclaimable request and confirms nothing happens.
    task automatic ignored(input logic [31:0] a, input logic [1:0] s, input string tag);
        int s0, r0;
        @(posedge clk); #1;
        sel_le = 1'b0;
        s0 = strobe_cnt; r0 = ready_cnt;
        addr = a; sz = s; wr = 1'b1; wdata = 32'hCAFE_F00D;
        vld_be = 1'b1;
        repeat (8) @(posedge clk);
        #1 vld_be = 1'b0;
        @(negedge clk);
        check(strobe_cnt == s0 && ready_cnt == r0, tag,
              32'(strobe_cnt - s0 + ready_cnt - r0), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rdy_be == 1'b0 && stb_be == 1'b0 && iow_be == 1'b0 && ioa_be == 16'h0 &&
              iosz_be == 2'b00, "R11 reset state",
              {13'h0, rdy_be, stb_be, iow_be, iosz_be, ioa_be}, 32'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(rdy_be == 1'b0 && stb_be == 1'b0, "R11 idle after reset",
              {30'h0, rdy_be, stb_be}, 32'h0);

        // Big-endian instance
        access(1'b0, 32'h7000_1234, 2'b10, 1'b1, 32'h1122_3344, 32'h0, "R6 be word write");
        access(1'b0, 32'h7000_03F8, 2'b01, 1'b1, 32'hAABB_1234, 32'h0, "R5 be half write");
        access(1'b0, 32'h7000_03F9, 2'b00, 1'b1, 32'h9988_775A, 32'h0, "R8 be byte write");
        access(1'b0, 32'h7000_0010, 2'b10, 1'b0, 32'h0, 32'hDEAD_BEEF, "R7 be word read");
        access(1'b0, 32'h7000_0012, 2'b01, 1'b0, 32'h0, 32'hFFFF_1234, "R7 be half read");
        access(1'b0, 32'h7000_0013, 2'b00, 1'b0, 32'h0, 32'h1234_56A5, "R8 be byte read");
        access(1'b0, 32'h7000_0000, 2'b00, 1'b0, 32'h0, 32'h0000_0081, "R1 low edge");
        access(1'b0, 32'h7000_FFFF, 2'b00, 1'b1, 32'h0000_00C3, 32'h0, "R1 high edge");

        // Unclaimed requests
        ignored(32'h7001_0000, 2'b00, "R1 above window");
        ignored(32'h6FFF_FFFC, 2'b10, "R1 below window");
        ignored(32'h7000_0020, 2'b11, "R10 reserved size");

        // Claimed request right after the ignored ones still works
        access(1'b0, 32'h7000_ABCD, 2'b10, 1'b0, 32'h0, 32'h0102_0304, "R4 after ignore");

        // Little-endian instance
        access(1'b1, 32'h7000_1234, 2'b10, 1'b1, 32'h1122_3344, 32'h0, "R9 le word write");
        access(1'b1, 32'h7000_0002, 2'b01, 1'b1, 32'hAABB_1234, 32'h0, "R9 le half write");
        access(1'b1, 32'h7000_0004, 2'b01, 1'b0, 32'h0, 32'hFFFF_1234, "R9 le half read");
        access(1'b1, 32'h7000_0008, 2'b10, 1'b0, 32'h0, 32'hDEAD_BEEF, "R9 le word read");
        access(1'b1, 32'h7000_0009, 2'b00, 1'b0, 32'h0, 32'hFFFF_FF7E, "R8 le byte read");

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "R4 every request completed", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule